// File: doc/BRIEF.md
# Interrupt-capable GPIO port with per-pin debounce

This block is one general-purpose I/O port of one to eight pins, attached to a simple register bus that uses separate write and read strobes. Each pin has its own 32-byte register window. Software uses it to set the pin's enable, direction and trigger, to program a debounce threshold in milliseconds, to read the qualified input level, to float or drive the pad, to set the level driven, and to acknowledge a latched edge interrupt. Every pad input first passes through a two-flop synchronizer. It can then go through a debounce filter, which counts millisecond ticks from a built-in prescaler.

An interrupt can be taken on a level, on a single edge or on both edges. A polarity bit picks high or rising versus low or falling. Edge events stay latched until software clears them. Level interrupts follow the qualified input. One port-wide status word gathers the pending bit of every pin, and the OR of those bits drives a single interrupt output. A read returns its data on `rd_data` in the cycle after `rd_en`, and holds it until the next read. A write takes effect at the clock edge where `wr_en` is high.

Top module: `gpio_port_ctl`

## Requirements
- R1: In pin n's window at byte address 32*n, offset 0x00 reads back the 7-bit configuration written to it. Its bits are: bit0 enable, bit1 output select, bits3:2 trigger type, bit4 polarity, bit5 debounce enable, bit6 interrupt enable. Offset 0x04 reads back an 8-bit debounce threshold. Upper bits written to either register read as zero.
- R2: `pad_oe[n]` is high exactly when enable and output select are both 1 and bit0 of output control (offset 0x0C) is 0. The new value is visible in the cycle after the write.
- R3: `pad_out[n]` equals bit0 of the output-value register (offset 0x10), whatever the direction. The level can therefore be set before the driver is turned on.
- R4: Bit0 of the input register (offset 0x08) returns the synchronized pad level within four cycles of a pad change when debounce is disabled or the threshold is 0.
- R5: With debounce enabled and a non-zero threshold N, the input level changes only after the synchronized pad has differed from it for N millisecond ticks in a row. A pulse shorter than that never appears.
- R6: The trigger type encodes the trigger mode: 00 none, 01 level (active when the input equals the polarity bit), 10 single edge (rising if polarity is 1, falling if 0), 11 both edges, whatever the polarity.
- R7: Writing 1 to bit0 at offset 0x14 clears the pin's latched edge event. Writing 0 there has no effect. A level interrupt is not latched, and clearing does not remove it while the level persists.
- R8: `irq` is high exactly when at least one pin's pending bit is high.
- R9: The status word at byte address 0x104 holds pin n's pending bit in bit n, and bits at or above the pin count read as zero. Windows of pins beyond the pin count read zero, and writes to them change nothing.
- R10: After reset every register is zero, `pad_oe`, `pad_out` and `irq` are low, and every read returns zero.
- R11: A pending bit is visible only while both enable and interrupt enable are 1. An edge latched while interrupt enable is 0 becomes visible once interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered one cycle after rd_en |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS | Level driven to each pad |
| pad_oe | output | NUM_PINS | Output enable per pad |
| irq | output | 1 | Port interrupt request |

## Verification
The trigger logic is swept over every pin, every trigger type and both polarities. Each case runs the same low-high-clear-low-clear sequence, so level, single-edge and double-edge detection can be told apart by the status word after each step. The output path is swept over all eight combinations of enable, direction and float per pin, which separates the output-enable condition from the driven level. All sixteen pad patterns are applied on the input path to catch crossed or stuck bits. The debounce filter gets a short glitch and then a long step, which shows both the rejection and the acceptance of a change against the programmed tick count.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // per-pin register offsets inside a 32-byte window
   localparam logic [4:0] OFS_CFG  = 5'h00;
   localparam logic [4:0] OFS_DBC  = 5'h04;
   localparam logic [4:0] OFS_IN   = 5'h08;
   localparam logic [4:0] OFS_OCTL = 5'h0C;
   localparam logic [4:0] OFS_OVAL = 5'h10;
   localparam logic [4:0] OFS_CLR  = 5'h14;
   localparam int         STATUS_ADDR = 'h104;
   localparam int         WIN_BITS    = 5;
   localparam int         PIN_BITS    = 3;

   typedef enum logic [1:0] {
      TRIG_NONE   = 2'b00,
      TRIG_LEVEL  = 2'b01,
      TRIG_SINGLE = 2'b10,
      TRIG_BOTH   = 2'b11
   } trig_e;

   // bit 0 is the LSB (en)
   typedef struct packed {
      logic  irq_en;
      logic  db_en;
      logic  pol;
      trig_e trig;
      logic  dir_out;
      logic  en;
   } pin_cfg_t;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
   parameter int TICK_DIV = 200000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV < 1) begin : g_bad
         $error("TICK_DIV must be at least 1");
      end
      if (TICK_DIV <= 1) begin : g_every
         assign tick = rst_n;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               tick_q <= 1'b0;
            end else if (cnt_q == CW'(TICK_DIV - 1)) begin
               cnt_q  <= '0;
               tick_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               tick_q <= 1'b0;
            end
         end
         assign tick = tick_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int DBC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             active,
   input  logic [DBC_W-1:0] thr,
   input  logic             din,
   output logic             dout
);
   logic             held_q;
   logic [DBC_W-1:0] cnt_q;
   logic [DBC_W:0]   cnt_next;

   assign cnt_next = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!active) begin
         held_q <= din;
         cnt_q  <= '0;
      end else if (din == held_q) begin
         cnt_q  <= '0;
      end else if (tick) begin
         if (cnt_next >= {1'b0, thr}) begin
            held_q <= din;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_next[DBC_W-1:0];
         end
      end
   end

   assign dout = active ? held_q : din;
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
   import gpio_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DBC_W       = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        sel_wr,
   input  logic [4:0]  ofs,
   input  logic [31:0] wdata,
   input  logic        pad_in,
   output logic        pad_out,
   output logic        pad_oe,
   output logic [31:0] rdata,
   output logic        pend,
   output logic        qual,
   output logic        db_act
);
   localparam int CFG_W = $bits(pin_cfg_t);

   pin_cfg_t         cfg_q;
   logic [DBC_W-1:0] thr_q;
   logic             float_q;
   logic             oval_q;
   logic             prev_q;
   logic             latch_q;
   logic             sync_lvl;
   logic             rise, fall, edge_hit, level_hit, clr_req, is_edge;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // synchronizer chain
   logic [SYNC_STAGES-1:0] sh_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], pad_in};
   end
   assign sync_lvl = sh_q[SYNC_STAGES-1];

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         thr_q   <= '0;
         float_q <= 1'b0;
         oval_q  <= 1'b0;
      end else if (sel_wr) begin
         case (ofs)
            OFS_CFG:  cfg_q   <= pin_cfg_t'(wdata[CFG_W-1:0]);
            OFS_DBC:  thr_q   <= wdata[DBC_W-1:0];
            OFS_OCTL: float_q <= wdata[0];
            OFS_OVAL: oval_q  <= wdata[0];
            default:  ;
         endcase
      end
   end

   assign db_act = cfg_q.db_en && (thr_q != '0);

   gpio_debounce #(.DBC_W(DBC_W)) u_dbc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .active (db_act),
      .thr    (thr_q),
      .din    (sync_lvl),
      .dout   (qual)
   );

   // trigger detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= qual;
   end

   assign rise      = qual & ~prev_q;
   assign fall      = ~qual & prev_q;
   assign clr_req   = sel_wr && (ofs == OFS_CLR) && wdata[0];
   assign is_edge   = (cfg_q.trig == TRIG_SINGLE) || (cfg_q.trig == TRIG_BOTH);
   assign level_hit = (cfg_q.trig == TRIG_LEVEL) && (qual == cfg_q.pol);

   always_comb begin
      edge_hit = 1'b0;
      if (cfg_q.en) begin
         case (cfg_q.trig)
            TRIG_SINGLE: edge_hit = cfg_q.pol ? rise : fall;
            TRIG_BOTH:   edge_hit = rise | fall;
            default:     edge_hit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= 1'b0;
      else if (edge_hit) latch_q <= 1'b1;
      else if (clr_req)  latch_q <= 1'b0;
   end

   assign pend = cfg_q.en && cfg_q.irq_en &&
                 (level_hit || (is_edge && latch_q));

   // pad drive
   assign pad_oe  = cfg_q.en && cfg_q.dir_out && !float_q;
   assign pad_out = oval_q;

   // read mux
   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_CFG:  rdata[CFG_W-1:0] = cfg_q;
         OFS_DBC:  rdata[DBC_W-1:0] = thr_q;
         OFS_IN:   rdata[0]         = qual;
         OFS_OCTL: rdata[0]         = float_q;
         OFS_OVAL: rdata[0]         = oval_q;
         default:  rdata            = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 12,
   parameter int TICK_DIV    = 200000,
   parameter int SYNC_STAGES = 2,
   parameter int DBC_W       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rd_data,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   localparam int WIN_TOP = WIN_BITS + PIN_BITS;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
         $error("NUM_PINS must be between 1 and 8");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
      if (DBC_W < 1 || DBC_W > 24) begin : g_bad_dbc
         $error("DBC_W out of range");
      end
   endgenerate

   logic                tick;
   logic                in_win;
   logic [PIN_BITS-1:0] pin_idx;
   logic [4:0]          ofs;
   logic [NUM_PINS-1:0] pend_vec;
   logic [NUM_PINS-1:0] qual_vec;
   logic [NUM_PINS-1:0] db_act_vec;
   logic [31:0]         pin_rdata [NUM_PINS];
   logic [31:0]         rd_next;

   assign in_win  = (addr[ADDR_W-1:WIN_TOP] == '0);
   assign pin_idx = addr[WIN_TOP-1:WIN_BITS];
   assign ofs     = addr[WIN_BITS-1:0];

   gpio_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel_wr;
      assign sel_wr = wr_en && in_win && (pin_idx == PIN_BITS'(p));

      gpio_pin_unit #(
         .SYNC_STAGES (SYNC_STAGES),
         .DBC_W       (DBC_W)
      ) u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .sel_wr  (sel_wr),
         .ofs     (ofs),
         .wdata   (wdata),
         .pad_in  (pad_in[p]),
         .pad_out (pad_out[p]),
         .pad_oe  (pad_oe[p]),
         .rdata   (pin_rdata[p]),
         .pend    (pend_vec[p]),
         .qual    (qual_vec[p]),
         .db_act  (db_act_vec[p])
      );
   end

   always_comb begin
      rd_next = '0;
      if (addr == ADDR_W'(STATUS_ADDR)) begin
         rd_next[NUM_PINS-1:0] = pend_vec;
      end else if (in_win) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == PIN_BITS'(p)) rd_next = pin_rdata[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   assign irq = |pend_vec;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                rd_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [31:0]         wdata,
   input logic [31:0]         rd_data,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                tick,
   input logic [NUM_PINS-1:0] qual_vec,
   input logic [NUM_PINS-1:0] db_act_vec
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
      localparam int BASE = p * 32;

      // R2: floating the pad removes output enable
      a_r2_float_off: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(BASE + 'h0C) && wdata[0]) |=> !pad_oe[p]);

      // R3: the pad level follows the output-value write
      a_r3_out_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(BASE + 'h10)) |=> (pad_out[p] == $past(wdata[0])));

      // R5: a filtered level moves only on a tick
      a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
         (db_act_vec[p] && !tick && !wr_en) |=> $stable(qual_vec[p]));
   end

   if (NUM_PINS < 32) begin : g_hi
      // R9: status bits above the pin count read zero
      a_r9_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == ADDR_W'(STATUS_ADDR)) |=> (rd_data[31:NUM_PINS] == '0));
   end
endmodule

bind gpio_port_ctl gpio_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_port_ctl_test.sv
`timescale 1ns/1ps
module gpio_port_ctl_test;
   localparam int NP = 4;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rd_data;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   gpio_port_ctl #(
      .NUM_PINS (NP), .ADDR_W (AW), .TICK_DIV (4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq(irq)
   );

   function automatic int pa(input int p, input int o);
      return p * 32 + o;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      settle(3);
      rst_n = 1'b1;
      settle(2);

      // R10: reset state
      chk("R10 pad_oe", 32'(pad_oe), 0);
      chk("R10 pad_out", 32'(pad_out), 0);
      chk("R10 irq", 32'(irq), 0);
      for (int p = 0; p < NP; p++)
         for (int o = 0; o <= 'h14; o += 4) begin
            rd(pa(p, o), d);
            chk("R10 reg", d, 0);
         end
      rd('h104, d); chk("R10 status", d, 0);

      // R1: readback of config and threshold
      for (int p = 0; p < NP; p++) begin
         logic [6:0] v;
         v = 7'h2A ^ 7'(p * 13);
         v[6] = 1'b0;
         wr(pa(p, 0), 32'hFFFF_FF80 | 32'(v));
         wr(pa(p, 4), 32'hABCD_0000 | 32'(8'hC3 + p));
      end
      for (int p = 0; p < NP; p++) begin
         logic [6:0] v;
         v = 7'h2A ^ 7'(p * 13);
         v[6] = 1'b0;
         rd(pa(p, 0), d); chk("R1 cfg", d, 32'(v));
         rd(pa(p, 4), d); chk("R1 dbc", d, 32'(8'hC3 + p));
         wr(pa(p, 0), 0);
         wr(pa(p, 4), 0);
      end

      // R2 / R3: output enable sweep and driven level
      for (int p = 0; p < NP; p++) begin
         wr(pa(p, 'h10), 1);
         chk("R3 level before drive", 32'(pad_out[p]), 1);
         chk("R3 oe still off", 32'(pad_oe[p]), 0);
         for (int c = 0; c < 8; c++) begin
            wr(pa(p, 0), 32'(c & 3));
            wr(pa(p, 'hC), 32'((c >> 2) & 1));
            chk("R2 pad_oe", 32'(pad_oe),
                32'((((c & 1) != 0) && ((c & 2) != 0) && ((c & 4) == 0)) ? (1 << p) : 0));
         end
         wr(pa(p, 'h10), 0);
         chk("R3 level low", 32'(pad_out[p]), 0);
         wr(pa(p, 0), 0);
         wr(pa(p, 'hC), 0);
      end

      // R4: input sampling, all pad patterns
      for (int p = 0; p < NP; p++) wr(pa(p, 0), 1);
      for (int v = 0; v < 16; v++) begin
         pad_in = NP'(v);
         settle(4);
         for (int p = 0; p < NP; p++) begin
            rd(pa(p, 8), d);
            chk("R4 input", d, 32'((v >> p) & 1));
         end
      end
      pad_in = '0;
      settle(4);

      // R6 / R7 / R8 / R9: trigger sweep
      for (int p = 0; p < NP; p++)
         for (int t = 0; t < 4; t++)
            for (int pol = 0; pol < 2; pol++) begin
               int e0, e1, e2, e3;
               e0 = (t == 1 && pol == 0) ? 1 : 0;
               e1 = (t == 1 || t == 2) ? pol : (t == 3 ? 1 : 0);
               e2 = (t == 1 && pol == 1) ? 1 : 0;
               e3 = (t == 1 || t == 2) ? (1 - pol) : (t == 3 ? 1 : 0);
               pad_in[p] = 1'b0;
               settle(4);
               wr(pa(p, 0), 32'(1 | (1 << 6) | (t << 2) | (pol << 4)));
               wr(pa(p, 'h14), 1);
               rd('h104, d); chk("R6 idle low", d, 32'(e0 << p));
               chk("R8 irq idle", 32'(irq), 32'(e0));
               pad_in[p] = 1'b1;
               settle(5);
               rd('h104, d); chk("R6 after rise", d, 32'(e1 << p));
               chk("R8 irq rise", 32'(irq), 32'(e1));
               wr(pa(p, 'h14), 1);
               rd('h104, d); chk("R7 after clear high", d, 32'(e2 << p));
               pad_in[p] = 1'b0;
               settle(5);
               rd('h104, d); chk("R6 after fall", d, 32'(e3 << p));
               wr(pa(p, 'h14), 1);
               rd('h104, d); chk("R7 after clear low", d, 32'(e0 << p));
               wr(pa(p, 0), 0);
            end

      // R11: masked edge becomes visible when interrupt enable set
      wr(pa(1, 0), 32'(1 | (2 << 2) | (1 << 4)));
      wr(pa(1, 'h14), 1);
      pad_in[1] = 1'b1;
      settle(5);
      rd('h104, d); chk("R11 masked", d, 0);
      chk("R11 irq masked", 32'(irq), 0);
      wr(pa(1, 0), 32'(1 | (1 << 6) | (2 << 2) | (1 << 4)));
      rd('h104, d); chk("R11 unmasked", d, 32'h2);
      // R7: clear with bit0 = 0 ignored
      wr(pa(1, 'h14), 32'hFFFF_FFFE);
      rd('h104, d); chk("R7 zero write ignored", d, 32'h2);
      // R8: two pins pending
      wr(pa(3, 0), 32'(1 | (1 << 6) | (3 << 2)));
      wr(pa(3, 'h14), 1);
      pad_in[3] = 1'b1;
      settle(5);
      rd('h104, d); chk("R8 two pending", d, 32'hA);
      wr(pa(1, 'h14), 1);
      chk("R8 irq one left", 32'(irq), 1);
      wr(pa(3, 'h14), 1);
      chk("R8 irq none", 32'(irq), 0);
      wr(pa(1, 0), 0);
      wr(pa(3, 0), 0);
      pad_in = '0;
      settle(5);

      // R9: status upper bits, pins beyond the count
      for (int p = 0; p < NP; p++) wr(pa(p, 0), 32'(1 | (1 << 6) | (1 << 2)));
      rd('h104, d); chk("R9 all low-level pending", d, 32'hF);
      for (int p = 0; p < NP; p++) wr(pa(p, 0), 0);
      wr(pa(5, 0), 32'h7F);
      rd(pa(5, 0), d); chk("R9 absent pin reads zero", d, 0);
      rd(pa(1, 0), d); chk("R9 no alias", d, 0);
      chk("R9 no drive", 32'(pad_oe), 0);

      // R5: debounce, threshold 5 ticks of 4 cycles
      wr(pa(2, 4), 5);
      wr(pa(2, 0), 32'(1 | (1 << 5)));
      settle(2);
      pad_in[2] = 1'b1;
      settle(6);
      pad_in[2] = 1'b0;
      settle(40);
      rd(pa(2, 8), d); chk("R5 glitch rejected", d, 0);
      pad_in[2] = 1'b1;
      settle(6);
      rd(pa(2, 8), d); chk("R5 early still low", d, 0);
      settle(30);
      rd(pa(2, 8), d); chk("R5 accepted", d, 1);
      // R4: threshold 0 bypasses filter
      wr(pa(2, 4), 0);
      pad_in[2] = 1'b0;
      settle(4);
      rd(pa(2, 8), d); chk("R4 zero threshold bypass", d, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule